// File: doc/BRIEF.md
# Secured Serial Configuration Store

This block holds the non-volatile setup of a small programmable logic device and is reached through a four-wire serial test port. It keeps three things. The first is a main fuse array of 5828 bits. The second is a separate 64-bit user signature, which may carry an ID code, a revision or any other data the user picks. The third is one security bit. Together the array and the signature make 5892 bits.

A host selects an operation by shifting an 8-bit opcode in while mode select is high. It then streams data in or out while mode select is low. The operations are:
- erase the whole device;
- program the array;
- program the signature;
- read the array;
- read the signature;
- arm security;
- read a sticky status flag.

Once the security bit is set, array readback shows only zeros, but the signature can still be read. Only a full erase clears the security bit, and that erase also wipes the array.

A programming session may write only the array and leave the signature alone, so an image that covers only the array is valid input.

Top module: `cfg_store`

## Requirements
- R1: After reset every array and signature bit is 1, the security bit and the status flag are 0, and `tdo_o` is 0.
- R2: On each rising `tck_i` edge with `tms_i` high, one opcode bit is taken from `tdi_i`, least significant bit first; the last 8 bits taken form the opcode. The first rising edge with `tms_i` low decodes the opcode and moves the bit index to 0. After k further low edges, a read presents bit k on `tdo_o`, and a program applies `tdi_i` to bit k on edge k+1.
- R3: Opcode 0x01 (erase) sets every array and signature bit to 1 and clears both the security bit and the status flag.
- R4: Opcode 0x02 (program array) ANDs data bit k into array bit k, so a bit can only go from 1 to 0. Data bits beyond index 5827 are ignored.
- R5: Opcode 0x03 (program signature) ANDs data bit k into signature bit k for k below 64. It leaves the array unchanged, and data past bit 63 is ignored.
- R6: Opcode 0x04 (read array) returns the stored array bits, index 0 first, while the security bit is 0.
- R7: Opcode 0x06 (arm security) sets the security bit. While the bit is set, an array read returns only zeros, and decoding that read sets the sticky status flag.
- R8: Opcode 0x05 (read signature) returns the stored signature bits, index 0 first, whatever the state of the security bit.
- R9: Opcode 0x07 (read status) drives the sticky flag on `tdo_o` for every data bit. The flag stays at 1 until an erase.
- R10: Program and read operations never clear the security bit; only erase or reset does.
- R11: Any other opcode has no effect on stored state, and `tdo_o` stays 0 during its data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Serial test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tms_i | input | 1 | Mode select: high shifts opcode, low shifts data |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |

## Verification
The assertions assume that `tms_i` and `tdi_i` change only away from the rising `tck_i` edge. They also assume that reset is held across at least one edge, so that the past-value checks on the fuse banks start from the erased state. The bench changes every input on the falling edge and samples `tdo_o` there. Each operation's data phase starts only after a complete 8-bit opcode, so the bit index the bench counts always matches the one inside the block.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [2:0] {
    OP_NOP, OP_ERASE, OP_PROG_ARR, OP_PROG_SIG,
    OP_RD_ARR, OP_RD_SIG, OP_ARM_SEC, OP_RD_STAT
  } op_e;

  localparam int CODE_W = 8;

  function automatic op_e decode_op(input logic [CODE_W-1:0] code);
    case (code)
      8'h01:   return OP_ERASE;
      8'h02:   return OP_PROG_ARR;
      8'h03:   return OP_PROG_SIG;
      8'h04:   return OP_RD_ARR;
      8'h05:   return OP_RD_SIG;
      8'h06:   return OP_ARM_SEC;
      8'h07:   return OP_RD_STAT;
      default: return OP_NOP;
    endcase
  endfunction
endpackage

// File: rtl/cfg_cmd_decoder.sv
module cfg_cmd_decoder
  import cfg_store_pkg::*;
#(
  parameter int PW = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  output op_e               op_o,
  output logic [CODE_W-1:0] code_o,
  output logic              start_o,
  output logic              shift_o,
  output logic [PW-1:0]     ptr_o
);
  logic [CODE_W-1:0] sr_q;
  logic              cmd_q;
  op_e               op_q;
  logic [PW-1:0]     ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cmd_q <= 1'b0;
      op_q  <= OP_NOP;
      ptr_q <= '0;
    end else if (tms_i) begin
      sr_q  <= {tdi_i, sr_q[CODE_W-1:1]};
      cmd_q <= 1'b1;
      op_q  <= OP_NOP;
    end else if (cmd_q) begin
      cmd_q <= 1'b0;
      op_q  <= decode_op(sr_q);
      ptr_q <= '0;
    end else if (ptr_q != '1) begin
      ptr_q <= ptr_q + 1'b1;  // saturate: trailing bits fall out of range
    end
  end

  assign op_o    = op_q;
  assign code_o  = sr_q;
  assign start_o = !tms_i && cmd_q;
  assign shift_o = !tms_i && !cmd_q;
  assign ptr_o   = ptr_q;

  assert_cmd_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tms_i |=> op_o == OP_NOP);
  assert_ptr_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> ptr_o == '0);
endmodule

// File: rtl/cfg_fuse_bank.sv
module cfg_fuse_bank #(
  parameter int WIDTH = 64,
  parameter int PW    = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] addr_i,
  input  logic          din_i,
  output logic          dout_o
);
  localparam int            AW    = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [PW-1:0] LIMIT = PW'(WIDTH);

  logic [WIDTH-1:0] mem_q;
  logic             in_rng;
  logic [AW-1:0]    idx;

  assign in_rng = addr_i < LIMIT;
  assign idx    = addr_i[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mem_q      <= '1;
    else if (erase_i)           mem_q      <= '1;
    else if (wr_en_i && in_rng) mem_q[idx] <= mem_q[idx] & din_i;
  end

  assign dout_o = in_rng ? mem_q[idx] : 1'b0;

  assert_erase_fills_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> &mem_q);
  assert_clear_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erase_i |=> (mem_q & ~$past(mem_q)) == '0);
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_store_pkg::*;
#(
  parameter int ARRAY_BITS = 5828,
  parameter int SIG_BITS   = 64
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tms_i,
  input  logic tdi_i,
  output logic tdo_o
);
  localparam int PW = $clog2(ARRAY_BITS + 1);

  op_e               op;
  logic [CODE_W-1:0] code;
  logic              start, shift;
  logic [PW-1:0]     ptr;
  logic              erase_w, arm_w, dark_rd_w;
  logic              arr_bit, sig_bit;
  logic              sec_q, flag_q;

  cfg_cmd_decoder #(.PW(PW)) u_dec (
    .clk_i(tck_i), .rst_ni(rst_ni), .tms_i(tms_i), .tdi_i(tdi_i),
    .op_o(op), .code_o(code), .start_o(start), .shift_o(shift), .ptr_o(ptr)
  );

  assign erase_w   = start && decode_op(code) == OP_ERASE;
  assign arm_w     = start && decode_op(code) == OP_ARM_SEC;
  assign dark_rd_w = start && decode_op(code) == OP_RD_ARR && sec_q;

  cfg_fuse_bank #(.WIDTH(ARRAY_BITS), .PW(PW)) u_arr (
    .clk_i(tck_i), .rst_ni(rst_ni), .erase_i(erase_w),
    .wr_en_i(shift && op == OP_PROG_ARR), .addr_i(ptr), .din_i(tdi_i),
    .dout_o(arr_bit)
  );

  cfg_fuse_bank #(.WIDTH(SIG_BITS), .PW(PW)) u_sig (
    .clk_i(tck_i), .rst_ni(rst_ni), .erase_i(erase_w),
    .wr_en_i(shift && op == OP_PROG_SIG), .addr_i(ptr), .din_i(tdi_i),
    .dout_o(sig_bit)
  );

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (erase_w) begin
      sec_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (arm_w)     sec_q  <= 1'b1;
      if (dark_rd_w) flag_q <= 1'b1;
    end
  end

  always_comb begin
    case (op)
      OP_RD_ARR:  tdo_o = arr_bit && !sec_q;
      OP_RD_SIG:  tdo_o = sig_bit;
      OP_RD_STAT: tdo_o = flag_q;
      default:    tdo_o = 1'b0;
    endcase
  end

  assert_secured_dark_R7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sec_q && op == OP_RD_ARR) |-> !tdo_o);
  assert_sec_only_erase_R10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $fell(sec_q) |-> $past(erase_w));
  assert_flag_sticky_R9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(erase_w));
  assert_nop_quiet_R11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (op == OP_NOP) |-> !tdo_o);
endmodule

// File: tb/tb_cfg_store.sv
`timescale 1ns/1ps
module tb_cfg_store;
  localparam int NA = 5828;
  localparam int NS = 64;

  logic clk = 1'b0, rst_n = 1'b0, tms = 1'b0, tdi = 1'b0;
  wire  tdo;

  always #2.5 clk = ~clk;

  cfg_store dut (.tck_i(clk), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi), .tdo_o(tdo));

  int  checks = 0, errors = 0;
  bit  done = 1'b0;
  bit  rd_buf [0:5999];
  bit  ref_arr [0:NA-1];
  bit  ref_sig [0:NS-1];
  bit  ref_sec, ref_flag;

  // step table: {opcode, seed}
  localparam int NSTEP = 16;
  localparam logic [15:0] STEPS [NSTEP] = '{
    16'h0100, 16'h0205, 16'h0400, 16'h0309, 16'h0500, 16'h0400,
    16'h0202, 16'h0400, 16'h0600, 16'h0400, 16'h0500, 16'h0304,
    16'h0400, 16'h0700, 16'h0100, 16'h0400
  };

  function automatic bit pat(int seed, int k);
    return ((((k * (seed + 3)) >> 2) ^ seed) % 2) != 0;
  endfunction

  function automatic string req_of(logic [7:0] op);
    case (op)
      8'h04:   return ref_sec ? "R7" : "R6";
      8'h05:   return "R8";
      8'h07:   return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic send_op(input logic [7:0] c);
    for (int i = 0; i < 8; i++) begin
      tms = 1'b1; tdi = c[i];
      @(negedge clk);
    end
    tms = 1'b0; tdi = 1'b0;
    @(negedge clk);
  endtask

  task automatic shift(input int n, input bit wr, input int seed);
    for (int k = 0; k < n; k++) begin
      rd_buf[k] = tdo;
      tdi = wr ? pat(seed, k) : 1'b0;
      @(negedge clk);
    end
    tdi = 1'b0;
  endtask

  function automatic bit expect_bit(logic [7:0] op, int k);
    case (op)
      8'h04:   return ref_sec ? 1'b0 : ref_arr[k];
      8'h05:   return ref_sig[k];
      8'h07:   return ref_flag;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_read(input logic [7:0] op, input int n, input string tag);
    int bad = 0, first = -1;
    for (int k = 0; k < n; k++)
      if (rd_buf[k] != expect_bit(op, k)) begin
        bad++;
        if (first < 0) first = k;
      end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s %s op=%h bit %0d: actual %b expected %b (%0d bad)", tag,
               req_of(op), op, first, rd_buf[first], expect_bit(op, first), bad);
    end
  endtask

  task automatic run_op(input logic [7:0] op, input int seed, input string tag);
    send_op(op);
    case (op)
      8'h01: begin
        foreach (ref_arr[k]) ref_arr[k] = 1'b1;
        foreach (ref_sig[k]) ref_sig[k] = 1'b1;
        ref_sec = 1'b0; ref_flag = 1'b0;
      end
      8'h02: begin
        shift(NA, 1'b1, seed);
        for (int k = 0; k < NA; k++) ref_arr[k] &= pat(seed, k);
      end
      8'h03: begin
        shift(NS, 1'b1, seed);
        for (int k = 0; k < NS; k++) ref_sig[k] &= pat(seed, k);
      end
      8'h04: begin
        if (ref_sec) ref_flag = 1'b1;
        shift(NA, 1'b0, 0);
        check_read(op, NA, tag);
      end
      8'h05: begin shift(NS, 1'b0, 0); check_read(op, NS, tag); end
      8'h06: ref_sec = 1'b1;
      8'h07: begin shift(8, 1'b0, 0); check_read(op, 8, tag); end
      default: begin shift(16, 1'b0, 0); check_read(op, 16, tag); end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (ref_arr[k]) ref_arr[k] = 1'b1;
    foreach (ref_sig[k]) ref_sig[k] = 1'b1;
    ref_sec = 1'b0; ref_flag = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (tdo !== 1'b0) begin
      errors++; $display("FAIL R1 tdo in reset: actual %b expected 0", tdo);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (tdo !== 1'b0) begin
      errors++; $display("FAIL R1 tdo after reset: actual %b expected 0", tdo);
    end
    // R1: reset contents read back erased
    run_op(8'h04, 0, "R1 array");
    run_op(8'h05, 0, "R1 sig");
    run_op(8'h07, 0, "R1 status");

    // table walk: R2..R10
    for (int s = 0; s < NSTEP; s++)
      run_op(STEPS[s][15:8], int'(STEPS[s][7:0]), $sformatf("step%0d", s));

    // R11: unknown opcode quiet and no effect
    run_op(8'h03, 7, "R5 setup");
    run_op(8'hA5, 0, "R11 quiet");
    run_op(8'h05, 0, "R11 sig kept");

    // R5/R4: over-length signature stream, array untouched
    send_op(8'h03);
    shift(70, 1'b1, 6);
    for (int k = 0; k < NS; k++) ref_sig[k] &= pat(6, k);
    run_op(8'h05, 0, "R5 overlen sig");
    run_op(8'h04, 0, "R5 array kept");

    // R10: arm, then program/read keep it armed; erase restores access
    run_op(8'h06, 0, "R7 arm");
    run_op(8'h02, 11, "R10 prog secured");
    run_op(8'h05, 0, "R8 sig secured");
    run_op(8'h04, 0, "R10 still dark");
    run_op(8'h07, 0, "R9 flag set");
    run_op(8'h01, 0, "R3 erase");
    run_op(8'h07, 0, "R3 flag clear");
    run_op(8'h04, 0, "R3 access back");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule